// File: doc/BRIEF.md
# Eight-Point Paired-Transform DFT Engine

This block computes an eight-point discrete Fourier transform of complex samples. It does not use radix-2 butterflies. Instead it splits the work into three separate steps:

- an add/subtract network that forms the paired-transform values;
- a twiddle stage that weights two short groups of those values;
- a set of short DFTs of different lengths (four-point, two-point and trivial) that deliver the spectrum in natural bin order.

All eight samples arrive in parallel and are qualified by a one-cycle start pulse. All eight bins leave in parallel, together with a one-cycle done pulse.

Samples are 16-bit signed real and imaginary parts. Inside the block the datapath carries extra guard bits. Each output bin is the true DFT value divided by eight, rounded to the nearest integer with halves going upward, and saturated to the 16-bit range. The block is a three-register pipeline: add, twiddle, then short DFT with output rounding. It accepts a new start on every cycle.

Top module: `paired_dft8`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and every output bin reads zero until the first result appears.
- R2: A start sampled at rising edge E raises done_o right after edge E+2 for exactly one cycle. done_o never rises without such a start.
- R3: Bin 0 and bin 4 equal floor(X/8 + 1/2) exactly, clamped to [-32768, 32767], where X is the exact DFT value X(k) = sum over n of x(n)·exp(-j2πnk/8).
- R4: Bin 2 and bin 6 equal the same exactly rounded value with no error.
- R5: The odd bins 1, 3, 5 and 7 come from the twiddle-weighted four-point DFT. Each lies within one LSB of the exactly rounded value, in both real and imaginary parts.
- R6: Rounding is to nearest with ties toward plus infinity. A sum of +4 gives 1, -4 gives 0, +12 gives 2 and -12 gives -1.
- R7: A result beyond the 16-bit range saturates to 32767 or -32768 rather than wrapping.
- R8: Inputs are sampled only at the start edge. Changes to x_re_i and x_im_i at any other time have no effect, and the outputs hold their last result until the next done.
- R9: Starts on consecutive cycles produce their results, in order, on consecutive done cycles.
- R10: Sample n occupies bits [16n+15:16n] of the input buses, and bin k occupies bits [16k+15:16k] of the output buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the eight samples and begin a transform |
| x_re_i | input | 128 | Real parts of samples 0..7, sample n at [16n+15:16n] |
| x_im_i | input | 128 | Imaginary parts of samples 0..7 |
| done_o | output | 1 | One-cycle pulse when a new result is on the outputs |
| y_re_o | output | 128 | Real parts of bins 0..7, bin k at [16k+15:16k] |
| y_im_o | output | 128 | Imaginary parts of bins 0..7 |

## Verification
The hardest case to reach is two transforms in flight at once. Here the add and twiddle registers hold different data sets in the same cycle, and a fault in stage enables only shows up when the second result is compared. The stimulus holds start high for two consecutive cycles with different sample sets and checks both results on back-to-back done cycles. Saturation is also hard to reach, because no set of equal samples can push a scaled bin past full scale. It is reached with full-scale samples whose signs follow the first-harmonic cosine and sine, so that every term adds into the real part of bin 1.

// File: rtl/paired_dft8.sv
module paired_dft8 #(
  parameter int DW   = 16,
  parameter int GROW = 3,
  parameter int CF   = 16
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            start_i,
  input  logic [8*DW-1:0] x_re_i,
  input  logic [8*DW-1:0] x_im_i,
  output logic            done_o,
  output logic [8*DW-1:0] y_re_o,
  output logic [8*DW-1:0] y_im_o
);
  localparam int IW = DW + GROW + 3;
  localparam int PW = IW + CF + 2;
  localparam longint KCI = $rtoi(0.7071067811865476 * (2.0 ** CF) + 0.5);
  localparam logic signed [PW-1:0] KC    = PW'(KCI);
  localparam logic signed [PW-1:0] KHALF = PW'(1) <<< (CF - 1);
  localparam logic signed [IW-1:0] RHALF = IW'(1) <<< (GROW - 1);
  localparam logic signed [IW-1:0] OMAX  = IW'((longint'(1) <<< (DW - 1)) - 1);
  localparam logic signed [IW-1:0] OMIN  = -OMAX - IW'(1);

  typedef logic signed [IW-1:0] sw_t;

  function automatic sw_t kmul(input sw_t v);
    logic signed [PW-1:0] pr;
    pr = PW'(v) * KC + KHALF;
    return sw_t'(pr >>> CF);
  endfunction

  function automatic logic [DW-1:0] shrink(input sw_t v);
    sw_t t;
    t = (v + RHALF) >>> GROW;
    if (t > OMAX) return OMAX[DW-1:0];
    if (t < OMIN) return OMIN[DW-1:0];
    return t[DW-1:0];
  endfunction

  // stage 1: additions only
  sw_t xr [8], xi [8];
  sw_t sr [4], si [4], dr [4], di [4];
  sw_t er0, ei0, er1, ei1;

  for (genvar n = 0; n < 8; n++) begin : g_in
    assign xr[n] = sw_t'($signed(x_re_i[n*DW +: DW]));
    assign xi[n] = sw_t'($signed(x_im_i[n*DW +: DW]));
  end

  for (genvar t = 0; t < 4; t++) begin : g_pair
    assign sr[t] = xr[t] + xr[t+4];
    assign si[t] = xi[t] + xi[t+4];
    assign dr[t] = xr[t] - xr[t+4];
    assign di[t] = xi[t] - xi[t+4];
  end

  assign er0 = sr[0] + sr[2];
  assign ei0 = si[0] + si[2];
  assign er1 = sr[1] + sr[3];
  assign ei1 = si[1] + si[3];

  sw_t a_r [4], a_i [4], b_r [2], b_i [2];
  sw_t c_r, c_i, z_r, z_i;
  logic v1;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      v1 <= 1'b0;
      for (int t = 0; t < 4; t++) begin
        a_r[t] <= '0;
        a_i[t] <= '0;
      end
      for (int t = 0; t < 2; t++) begin
        b_r[t] <= '0;
        b_i[t] <= '0;
      end
      c_r <= '0;
      c_i <= '0;
      z_r <= '0;
      z_i <= '0;
    end else begin
      v1 <= start_i;
      if (start_i) begin
        for (int t = 0; t < 4; t++) begin
          a_r[t] <= dr[t];
          a_i[t] <= di[t];
        end
        for (int t = 0; t < 2; t++) begin
          b_r[t] <= sr[t] - sr[t+2];
          b_i[t] <= si[t] - si[t+2];
        end
        c_r <= er0 - er1;
        c_i <= ei0 - ei1;
        z_r <= er0 + er1;
        z_i <= ei0 + ei1;
      end
    end
  end

  // stage 2: twiddle weighting of the 4- and 2-element groups
  sw_t q_r [4], q_i [4];
  sw_t m_r, m_i;

  assign q_r[0] = a_r[0];
  assign q_i[0] = a_i[0];
  assign q_r[1] = kmul(a_r[1] + a_i[1]);
  assign q_i[1] = kmul(a_i[1] - a_r[1]);
  assign q_r[2] = a_i[2];
  assign q_i[2] = -a_r[2];
  assign q_r[3] = kmul(a_i[3] - a_r[3]);
  assign q_i[3] = kmul(-a_r[3] - a_i[3]);
  assign m_r    = b_i[1];
  assign m_i    = -b_r[1];

  sw_t g_r [4], g_i [4];
  sw_t h_r, h_i, w_r, w_i, c2_r, c2_i, z2_r, z2_i;
  logic v2;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      v2 <= 1'b0;
      for (int t = 0; t < 4; t++) begin
        g_r[t] <= '0;
        g_i[t] <= '0;
      end
      h_r  <= '0;
      h_i  <= '0;
      w_r  <= '0;
      w_i  <= '0;
      c2_r <= '0;
      c2_i <= '0;
      z2_r <= '0;
      z2_i <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        for (int t = 0; t < 4; t++) begin
          g_r[t] <= q_r[t];
          g_i[t] <= q_i[t];
        end
        h_r  <= b_r[0];
        h_i  <= b_i[0];
        w_r  <= m_r;
        w_i  <= m_i;
        c2_r <= c_r;
        c2_i <= c_i;
        z2_r <= z_r;
        z2_i <= z_i;
      end
    end
  end

  // stage 3: short DFTs, natural-order placement, rounding
  sw_t f_r [8], f_i [8];

  assign f_r[0] = z2_r;
  assign f_i[0] = z2_i;
  assign f_r[4] = c2_r;
  assign f_i[4] = c2_i;
  assign f_r[2] = h_r + w_r;
  assign f_i[2] = h_i + w_i;
  assign f_r[6] = h_r - w_r;
  assign f_i[6] = h_i - w_i;
  assign f_r[1] = g_r[0] + g_r[1] + g_r[2] + g_r[3];
  assign f_i[1] = g_i[0] + g_i[1] + g_i[2] + g_i[3];
  assign f_r[3] = g_r[0] + g_i[1] - g_r[2] - g_i[3];
  assign f_i[3] = g_i[0] - g_r[1] - g_i[2] + g_r[3];
  assign f_r[5] = g_r[0] - g_r[1] + g_r[2] - g_r[3];
  assign f_i[5] = g_i[0] - g_i[1] + g_i[2] - g_i[3];
  assign f_r[7] = g_r[0] - g_i[1] - g_r[2] + g_i[3];
  assign f_i[7] = g_i[0] + g_r[1] - g_i[2] - g_r[3];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      done_o <= 1'b0;
      y_re_o <= '0;
      y_im_o <= '0;
    end else begin
      done_o <= v2;
      if (v2) begin
        for (int k = 0; k < 8; k++) begin
          y_re_o[k*DW +: DW] <= shrink(f_r[k]);
          y_im_o[k*DW +: DW] <= shrink(f_i[k]);
        end
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_n_i) start_i |-> ##3 done_o); // R2
  AST_DONE_HAS_START: assert property (@(posedge clk_i) disable iff (!rst_n_i) done_o |-> $past(start_i, 3)); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_n_i) !done_o |-> ($stable(y_re_o) && $stable(y_im_o))); // R8
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk_i) disable iff (!rst_n_i) (start_i && x_re_i == '0 && x_im_i == '0) |-> ##3 (y_re_o == '0 && y_im_o == '0)); // R3
endmodule

// File: tb/test_paired_dft8.sv
module test_paired_dft8;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] xr = '0, xi = '0;
  logic         done;
  logic [127:0] yr, yi;

  int n_checks = 0, n_errors = 0, cyc = 0;
  int sre [8], sim [8];
  int exp_re [8], exp_im [8];

  paired_dft8 i_paired_dft8 (
    .clk_i(clk), .rst_n_i(rst_n), .start_i(start),
    .x_re_i(xr), .x_im_i(xi),
    .done_o(done), .y_re_o(yr), .y_im_o(yi)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  function automatic real cwf(int m);
    case (m)
      0: return 1.0;
      1, 7: return 0.7071067811865476;
      3, 5: return -0.7071067811865476;
      4: return -1.0;
      default: return 0.0;
    endcase
  endfunction

  function automatic real swf(int m);
    case (m)
      2: return 1.0;
      1, 3: return 0.7071067811865476;
      5, 7: return -0.7071067811865476;
      6: return -1.0;
      default: return 0.0;
    endcase
  endfunction

  function automatic int qz(real v);
    real f;
    f = $floor(v / 8.0 + 0.5);
    if (f > 32767.0) f = 32767.0;
    if (f < -32768.0) f = -32768.0;
    return $rtoi(f);
  endfunction

  task automatic calc();
    for (int k = 0; k < 8; k++) begin
      real ar, ai;
      ar = 0.0;
      ai = 0.0;
      for (int n = 0; n < 8; n++) begin
        int m;
        m = (n * k) % 8;
        ar += sre[n] * cwf(m) + sim[n] * swf(m);
        ai += sim[n] * cwf(m) - sre[n] * swf(m);
      end
      exp_re[k] = qz(ar);
      exp_im[k] = qz(ai);
    end
    for (int n = 0; n < 8; n++) begin
      xr[16*n +: 16] = 16'(sre[n]);
      xi[16*n +: 16] = 16'(sim[n]);
    end
  endtask

  task automatic check(bit ok, string req, string what, int got, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  task automatic check_bins(string req, int er [8], int ei [8]);
    for (int k = 0; k < 8; k++) begin
      int gr, gi, tol, dre, dim;
      gr  = int'($signed(yr[16*k +: 16]));
      gi  = int'($signed(yi[16*k +: 16]));
      tol = (k % 2 == 1) ? 1 : 0;
      dre = (gr > er[k]) ? gr - er[k] : er[k] - gr;
      dim = (gi > ei[k]) ? gi - ei[k] : ei[k] - gi;
      check(dre <= tol, req, $sformatf("bin %0d re", k), gr, er[k]);
      check(dim <= tol, req, $sformatf("bin %0d im", k), gi, ei[k]);
    end
  endtask

  task automatic transform(string req);
    calc();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R2", "done after 1 edge", int'(done), 0);
    xr = ~xr;
    xi = {xi[63:0], xi[127:64]};
    @(negedge clk);
    check(done == 1'b0, "R2", "done after 2 edges", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R2", "done after 3 edges", int'(done), 1);
    check_bins(req, exp_re, exp_im);
    @(negedge clk);
    check(done == 1'b0, "R2", "done pulse width", int'(done), 0);
    check_bins("R8", exp_re, exp_im);
  endtask

  task automatic fill(int r, int i);
    for (int n = 0; n < 8; n++) begin
      sre[n] = r;
      sim[n] = i;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(yr == '0 && yi == '0, "R1", "bins in reset", int'(yr[15:0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(yr == '0 && yi == '0, "R1", "bins after reset", int'(yr[15:0]), 0);
  endtask

  task automatic t_rounding();
    int vals [4] = '{4, -4, 12, -12};
    int want [4] = '{1, 0, 2, -1};
    foreach (vals[v]) begin
      int er [8], ei [8];
      fill(0, 0);
      sre[0] = vals[v];
      calc();
      for (int k = 0; k < 8; k++) begin
        er[k] = want[v];
        ei[k] = 0;
      end
      check(exp_re[3] == want[v], "R6", "model tie value", exp_re[3], want[v]);
      transform("R6");
      check_bins("R6", er, ei);
    end
  endtask

  task automatic t_dc();
    fill(1000, -2000);
    transform("R3");
    check(int'($signed(yr[15:0])) == 1000, "R3", "bin 0 re", int'($signed(yr[15:0])), 1000);
    check(int'($signed(yi[15:0])) == -2000, "R3", "bin 0 im", int'($signed(yi[15:0])), -2000);
    fill(-32768, -32768);
    transform("R3");
  endtask

  task automatic t_tones();
    for (int n = 0; n < 8; n++) begin
      sre[n] = $rtoi(15000.0 * cwf((2 * n) % 8));
      sim[n] = $rtoi(15000.0 * swf((2 * n) % 8));
    end
    transform("R4");
    for (int n = 0; n < 8; n++) begin
      sre[n] = (n % 2 == 0) ? 7000 : -7000;
      sim[n] = (n % 2 == 0) ? -333 : 333;
    end
    transform("R3");
    for (int n = 0; n < 8; n++) begin
      sre[n] = $rtoi(20000.0 * cwf((3 * n) % 8));
      sim[n] = $rtoi(20000.0 * swf((3 * n) % 8));
    end
    transform("R5");
  endtask

  task automatic t_packing();
    fill(0, 0);
    sre[5] = 800;
    sim[2] = -1600;
    transform("R10");
  endtask

  task automatic t_random();
    logic [31:0] seed = 32'h1234_5678;
    for (int p = 0; p < 6; p++) begin
      for (int n = 0; n < 8; n++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        sre[n] = int'($signed(seed[31:16]));
        seed = seed * 32'd1103515245 + 32'd12345;
        sim[n] = int'($signed(seed[31:16]));
      end
      transform("R5");
    end
  endtask

  task automatic t_saturation();
    int rs [8] = '{32767, 32767, 32767, -32767, -32767, -32767, 32767, 32767};
    int is [8] = '{32767, 32767, 32767, 32767, 32767, -32767, -32767, -32767};
    foreach (rs[n]) begin
      sre[n] = rs[n];
      sim[n] = is[n];
    end
    calc();
    check(exp_re[1] == 32767, "R7", "model clamp", exp_re[1], 32767);
    transform("R7");
    for (int n = 0; n < 8; n++) begin
      sre[n] = -rs[n] - 1;
      sim[n] = -is[n] - 1;
    end
    transform("R7");
  endtask

  task automatic t_idle();
    int er [8], ei [8];
    fill(123, -456);
    transform("R3");
    er = exp_re;
    ei = exp_im;
    for (int c = 0; c < 5; c++) begin
      xr = xr + 128'd777 * 128'(c + 1);
      xi = ~xi;
      @(negedge clk);
      check(done == 1'b0, "R2", "done without start", int'(done), 0);
    end
    check_bins("R8", er, ei);
  endtask

  task automatic t_back_to_back();
    int ar [8], ai [8];
    fill(0, 0);
    for (int n = 0; n < 8; n++) begin
      sre[n] = 1000 * n - 3000;
      sim[n] = 500 - 250 * n;
    end
    calc();
    ar = exp_re;
    ai = exp_im;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 8; n++) begin
      sre[n] = (n == 3) ? 16000 : -100;
      sim[n] = (n == 6) ? -9000 : 50;
    end
    calc();
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R9", "done before first result", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R9", "first done", int'(done), 1);
    check_bins("R9", ar, ai);
    @(negedge clk);
    check(done == 1'b1, "R9", "second done", int'(done), 1);
    check_bins("R9", exp_re, exp_im);
    @(negedge clk);
    check(done == 1'b0, "R9", "done after pair", int'(done), 0);
  endtask

  initial begin
    t_reset();
    t_rounding();
    t_dc();
    t_tones();
    t_packing();
    t_random();
    t_saturation();
    t_idle();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule